// File: doc/BRIEF.md
# Memory-Mapped SPI Master

This block connects an 8-bit processor memory bus to a small SPI link. The processor reaches it through a memory request strobe, separate read and write strobes and an 8-bit data path. Only the upper address bits decide where an access goes. The block recognises one 16 KB page. The lower three quarters of that page enable an external ROM through a chip-enable output. The top 4 KB window holds four registers, and they repeat across the whole window.

Software selects either of two slaves by setting bits in the control register, then writes a byte to the data register. The block sends that byte in SPI mode 0, most significant bit first, and captures the reply at the same time. A second kind of operation sends clock pulses only: it emits a programmable number of bytes' worth of SCLK pulses with both selects forced high and MOSI held high. Cards that use a serial storage protocol need this sequence to wake up.

Top module: `spi_mm_master`

## Requirements
- R1: An access is qualified by `mreq_ni` low together with `rd_ni` or `wr_ni` low. When `addr_i[21:14]` equals `PAGE_BASE` and `addr_i[13:12]` is not `2'b11`, `rom_ce_no` goes low. It stays high for every other access, for the register window, and whenever `mreq_ni` is high.
- R2: The register window is `addr_i[13:12] == 2'b11` within the page. `addr_i[1:0]` picks the register: 0 data, 1 control, 2 clock divider, 3 burst length in bytes. `addr_i[11:2]` is ignored, so the four registers alias throughout the window.
- R3: `data_oe_o` is high only while the window is addressed with `mreq_ni` and `rd_ni` both low. During that time `data_o` carries the selected register.
- R4: In the control register, bits [1:0] are the select enables for slaves 0 and 1. Writing bit 2 as 1 starts a clock burst. A read returns busy in bit 7, the select enables in bits [1:0], and zeros elsewhere.
- R5: SCLK idles low. Writing the data register while idle starts an 8-bit mode 0 transfer. MOSI presents the bits MSB first and changes only while SCLK is low.
- R6: The SCLK period is 2*(div+1) system clocks, where div is the value in the divider register.
- R7: MISO is sampled on each rising SCLK edge, MSB first. Once busy clears, a read of the data register returns the assembled byte. A clock burst leaves that byte unchanged.
- R8: Outside a burst, `ss_no[n]` equals the inverse of control bit n, so a select can stay asserted across several bytes.
- R9: A burst of length L produces exactly 8*L SCLK pulses. During it, `ss_no` is all ones and MOSI is high. When L is 0, a burst start produces no pulses and busy stays clear.
- R10: Busy is set in the cycle after a start. It stays set until SCLK returns low after the last rising edge. While busy, writes to any register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 22 | CPU address A21..A0 |
| mreq_ni | input | 1 | Memory request strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Write data from the CPU |
| data_o | output | 8 | Read data to the CPU |
| data_oe_o | output | 1 | Enable for the data pad tristate; low means high impedance |
| rom_ce_no | output | 1 | External ROM chip enable, active low |
| sclk_o | output | 1 | SPI clock, mode 0 |
| mosi_o | output | 1 | Serial data to the slaves |
| miso_i | input | 1 | Serial data from the slaves |
| ss_no | output | 2 | Slave selects, active low |

## Verification
A CPU bus write can arrive in a cycle where the shift engine is still running, whether it is part-way through a byte or in the middle of a clock burst. The bench provokes this by writing the data and divider registers during a byte transfer, and by writing the data register during a burst. The scoreboard then confirms three things: the number of SCLK pulses matches what was queued, the SCLK period and the divider readback are unchanged, and the received byte is still the one from the last real transfer. A status read during a busy period is also judged against the busy bit it must show.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_DIV  = 2'd2,
    REG_LEN  = 2'd3
  } reg_sel_e;

  localparam int unsigned WIN_CODE = 3;  // addr[13:12] of the register window
endpackage

// File: rtl/spi_mm_decode.sv
module spi_mm_decode
  import spi_mm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned PAGE_BASE = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mreq_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output logic              rom_ce_no,
  output logic              win_rd_o,
  output logic              win_wr_o,
  output reg_sel_e          reg_sel_o
);
  localparam int unsigned PAGE_W = ADDR_W - 14;

  logic page_hit, win_hit, access;
  logic unused_mid;

  assign unused_mid = ^addr_i[11:2];
  assign page_hit   = addr_i[ADDR_W-1:14] == PAGE_W'(PAGE_BASE);
  assign win_hit    = page_hit && (addr_i[13:12] == 2'(WIN_CODE));
  assign access     = !mreq_ni && (!rd_ni || !wr_ni);

  assign rom_ce_no  = !(page_hit && !win_hit && access);
  assign win_rd_o   = win_hit && !mreq_ni && !rd_ni;
  assign win_wr_o   = win_hit && !mreq_ni && !wr_ni;
  assign reg_sel_o  = reg_sel_e'(addr_i[1:0]);
endmodule

// File: rtl/spi_mm_regs.sv
module spi_mm_regs
  import spi_mm_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned LEN_W = 8,
  parameter int unsigned NSS   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_rd_i,
  input  logic             win_wr_i,
  input  reg_sel_e         reg_sel_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    data_o,
  output logic             data_oe_o,
  input  logic             busy_i,
  input  logic [DW-1:0]    rx_i,
  output logic [DW-1:0]    div_o,
  output logic [LEN_W-1:0] len_o,
  output logic [NSS-1:0]   sel_o,
  output logic             start_xfer_o,
  output logic             start_burst_o
);
  localparam int unsigned BURST_BIT = NSS;

  logic             wr_q;
  logic             accept;
  logic [DW-1:0]    div_q;
  logic [LEN_W-1:0] len_q;
  logic [NSS-1:0]   sel_q;
  logic [DW-1:0]    ctrl_rd;

  // one write per strobe, dropped while the engine runs
  assign accept        = win_wr_i && !wr_q && !busy_i;
  assign start_xfer_o  = accept && (reg_sel_i == REG_DATA);
  assign start_burst_o = accept && (reg_sel_i == REG_CTRL) && data_i[BURST_BIT]
                         && (len_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      div_q <= '0;
      len_q <= '0;
      sel_q <= '0;
    end else begin
      wr_q <= win_wr_i;
      if (accept) begin
        unique case (reg_sel_i)
          REG_CTRL: sel_q <= data_i[NSS-1:0];
          REG_DIV:  div_q <= data_i;
          REG_LEN:  len_q <= data_i[LEN_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[DW-1]    = busy_i;
    ctrl_rd[NSS-1:0] = sel_q;
    unique case (reg_sel_i)
      REG_DATA: data_o = rx_i;
      REG_CTRL: data_o = ctrl_rd;
      REG_DIV:  data_o = div_q;
      default:  data_o = DW'(len_q);
    endcase
  end

  assign data_oe_o = win_rd_i;
  assign div_o     = div_q;
  assign len_o     = len_q;
  assign sel_o     = sel_q;
endmodule

// File: rtl/spi_mm_engine.sv
module spi_mm_engine #(
  parameter int unsigned DW    = 8,
  parameter int unsigned LEN_W = 8,
  parameter int unsigned NSS   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_xfer_i,
  input  logic             start_burst_i,
  input  logic [DW-1:0]    tx_i,
  input  logic [DW-1:0]    div_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [NSS-1:0]   sel_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic [NSS-1:0]   ss_no,
  output logic             busy_o,
  output logic             burst_o,
  output logic [DW-1:0]    rx_o
);
  localparam int unsigned SH_W  = $clog2(DW);
  localparam int unsigned CNT_W = LEN_W + SH_W;

  logic             busy_q, burst_q, sclk_q, tick;
  logic [DW-1:0]    div_cnt_q, tx_q, rx_sh_q, rx_q;
  logic [CNT_W-1:0] left_q;  // rising edges still to come

  assign tick = busy_q && (div_cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      burst_q   <= 1'b0;
      sclk_q    <= 1'b0;
      div_cnt_q <= '0;
      left_q    <= '0;
      tx_q      <= '0;
      rx_sh_q   <= '0;
      rx_q      <= '0;
    end else if (start_xfer_i || start_burst_i) begin
      busy_q    <= 1'b1;
      burst_q   <= start_burst_i;
      sclk_q    <= 1'b0;
      div_cnt_q <= '0;
      tx_q      <= tx_i;
      left_q    <= start_burst_i ? {len_i, {SH_W{1'b0}}} : CNT_W'(DW);
    end else if (tick) begin
      div_cnt_q <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        left_q <= left_q - 1'b1;
        if (!burst_q) rx_sh_q <= {rx_sh_q[DW-2:0], miso_i};
      end else begin
        sclk_q <= 1'b0;
        if (left_q == '0) begin
          busy_q <= 1'b0;
          if (!burst_q) rx_q <= rx_sh_q;
        end else begin
          tx_q <= {tx_q[DW-2:0], 1'b0};
        end
      end
    end else if (busy_q) begin
      div_cnt_q <= div_cnt_q + 1'b1;
    end
  end

  assign burst_o = busy_q && burst_q;
  assign busy_o  = busy_q;
  assign sclk_o  = sclk_q;
  assign mosi_o  = (!busy_q || burst_q) ? 1'b1 : tx_q[DW-1];
  assign ss_no   = burst_o ? '1 : ~sel_i;
  assign rx_o    = rx_q;
endmodule

// File: rtl/spi_mm_master.sv
module spi_mm_master
  import spi_mm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned PAGE_BASE = 5,
  parameter int unsigned DW        = 8,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned NSS       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mreq_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic              data_oe_o,
  output logic              rom_ce_no,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NSS-1:0]    ss_no
);
  logic             win_rd, win_wr, busy_w, burst_w, start_xfer, start_burst;
  reg_sel_e         reg_sel;
  logic [DW-1:0]    rx_w, div_w;
  logic [LEN_W-1:0] len_w;
  logic [NSS-1:0]   sel_w;

  spi_mm_decode #(.ADDR_W(ADDR_W), .PAGE_BASE(PAGE_BASE)) u_dec (
    .addr_i, .mreq_ni, .rd_ni, .wr_ni, .rom_ce_no,
    .win_rd_o(win_rd), .win_wr_o(win_wr), .reg_sel_o(reg_sel)
  );

  spi_mm_regs #(.DW(DW), .LEN_W(LEN_W), .NSS(NSS)) u_regs (
    .clk_i, .rst_ni, .win_rd_i(win_rd), .win_wr_i(win_wr), .reg_sel_i(reg_sel),
    .data_i, .data_o, .data_oe_o, .busy_i(busy_w), .rx_i(rx_w),
    .div_o(div_w), .len_o(len_w), .sel_o(sel_w),
    .start_xfer_o(start_xfer), .start_burst_o(start_burst)
  );

  spi_mm_engine #(.DW(DW), .LEN_W(LEN_W), .NSS(NSS)) u_eng (
    .clk_i, .rst_ni, .start_xfer_i(start_xfer), .start_burst_i(start_burst),
    .tx_i(data_i), .div_i(div_w), .len_i(len_w), .sel_i(sel_w), .miso_i,
    .sclk_o, .mosi_o, .ss_no, .busy_o(busy_w), .burst_o(burst_w), .rx_o(rx_w)
  );
endmodule

// File: rtl/spi_mm_chk.sv
module spi_mm_chk #(
  parameter int unsigned NSS = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mreq_ni,
  input logic           rd_ni,
  input logic           data_oe_o,
  input logic           rom_ce_no,
  input logic           sclk_o,
  input logic           mosi_o,
  input logic [NSS-1:0] ss_no,
  input logic           busy_i,
  input logic           burst_i
);
  // R3
  oe_only_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!rd_ni && !mreq_ni));

  // R1
  rom_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_ce_no |-> (!mreq_ni && !data_oe_o));

  // R5
  sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sclk_o);

  // R6
  sclk_moves_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_o) |-> (busy_i || $past(busy_i)));

  // R9
  burst_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_i && $rose(sclk_o)) |-> (mosi_o && (ss_no == '1)));

  // R10
  busy_ends_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> !sclk_o);
endmodule

bind spi_mm_master spi_mm_chk #(.NSS(NSS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mreq_ni(mreq_ni), .rd_ni(rd_ni),
  .data_oe_o(data_oe_o), .rom_ce_no(rom_ce_no), .sclk_o(sclk_o),
  .mosi_o(mosi_o), .ss_no(ss_no), .busy_i(busy_w), .burst_i(burst_w)
);

// File: tb/tb_spi_mm_master.sv
module tb_spi_mm_master;
  localparam logic [7:0] PAGE = 8'h05;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [21:0] addr = '0;
  logic        mreq_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [7:0]  data_i = '0, data_o;
  logic        data_oe_o, rom_ce_no, sclk_o, mosi_o, miso_i;
  logic [1:0]  ss_no;

  spi_mm_master dut (
    .clk_i(clk), .rst_ni, .addr_i(addr), .mreq_ni, .rd_ni, .wr_ni,
    .data_i, .data_o, .data_oe_o, .rom_ce_no, .sclk_o, .mosi_o, .miso_i, .ss_no
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // slave model: first bit on MISO before the first rising edge
  logic [7:0] sreg = '0;
  assign miso_i = sreg[7];
  always @(negedge sclk_o) sreg = {sreg[6:0], 1'b0};

  // scoreboard
  typedef struct { logic [7:0] mosi; logic [1:0] ss; } item_t;
  item_t q[$];
  item_t cur;
  int exp_period = 2;
  int mon_bit = 0, last_cyc = 0, edges = 0;
  logic [7:0] mon_byte = '0;
  bit ss_bad = 0;

  always @(posedge sclk_o) begin
    #1;
    edges++;
    if (mon_bit == 0) begin
      ss_bad = 0;
      if (q.size() == 0) begin
        chk(0, "R9", "unexpected sclk pulse", edges, 0);
        cur.mosi = 'x; cur.ss = 'x;
      end else cur = q.pop_front();
    end else begin
      chk(cyc - last_cyc == exp_period, "R6", "sclk period", cyc - last_cyc, exp_period);
    end
    last_cyc = cyc;
    mon_byte = {mon_byte[6:0], mosi_o};
    if (ss_no !== cur.ss) ss_bad = 1;
    if (mon_bit == 7) begin
      chk(mon_byte === cur.mosi, "R5", "mosi byte", mon_byte, cur.mosi);
      chk(!ss_bad, "R8", "selects during byte", ss_no, cur.ss);
      mon_bit = 0;
    end else mon_bit++;
  end

  function automatic logic [21:0] win_addr(input logic [1:0] off, input logic [9:0] mid);
    return {PAGE, 2'b11, mid, off};
  endfunction

  task automatic bus_write(input logic [1:0] off, input logic [7:0] d,
                           input logic [9:0] mid = 10'h000);
    @(negedge clk);
    addr = win_addr(off, mid); data_i = d; mreq_ni = 0; wr_ni = 0;
    @(negedge clk);
    mreq_ni = 1; wr_ni = 1;
  endtask

  task automatic bus_read(input logic [1:0] off, output logic [7:0] d,
                          input logic [9:0] mid = 10'h000);
    @(negedge clk);
    addr = win_addr(off, mid); mreq_ni = 0; rd_ni = 0;
    @(negedge clk);
    d = data_o;
    mreq_ni = 1; rd_ni = 1;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      bus_read(2'd1, s);
      if (!s[7]) return;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slave_b,
                      input logic [1:0] ss_exp, input int div);
    item_t it;
    logic [7:0] r;
    exp_period = 2 * (div + 1);
    it.mosi = tx; it.ss = ss_exp;
    q.push_back(it);
    sreg = slave_b;
    bus_write(2'd0, tx);
    wait_idle();
    bus_read(2'd0, r);
    chk(r == slave_b, "R7", "received byte", r, slave_b);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(0, "WDOG", "run timed out", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [7:0] r;
    int e0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // reset state
    chk(ss_no == 2'b11, "R8", "reset selects", ss_no, 3);
    chk(sclk_o == 0, "R5", "reset sclk", sclk_o, 0);
    chk(data_oe_o == 0, "R3", "reset oe", data_oe_o, 0);
    chk(rom_ce_no == 1, "R1", "reset rom ce", rom_ce_no, 1);

    // R1 ROM decode
    @(negedge clk);
    addr = {PAGE, 2'b01, 12'h123}; mreq_ni = 0; rd_ni = 0;
    #1;
    chk(rom_ce_no == 0, "R1", "rom ce in rom area", rom_ce_no, 0);
    chk(data_oe_o == 0, "R3", "oe in rom area", data_oe_o, 0);
    addr = {8'h06, 2'b01, 12'h123}; #1;
    chk(rom_ce_no == 1, "R1", "rom ce other page", rom_ce_no, 1);
    addr = {PAGE, 2'b11, 12'h000}; #1;
    chk(rom_ce_no == 1, "R1", "rom ce in window", rom_ce_no, 1);
    chk(data_oe_o == 1, "R3", "oe on window read", data_oe_o, 1);
    mreq_ni = 1; #1;
    chk(data_oe_o == 0, "R3", "oe without mreq", data_oe_o, 0);
    addr = {PAGE, 2'b00, 12'h000}; #1;
    chk(rom_ce_no == 1, "R1", "rom ce without mreq", rom_ce_no, 1);
    rd_ni = 1; mreq_ni = 0; wr_ni = 0; #1;
    chk(rom_ce_no == 0, "R1", "rom ce on write", rom_ce_no, 0);
    addr = {PAGE, 2'b11, 12'h002}; data_i = 8'h00; #1;
    chk(data_oe_o == 0, "R3", "oe on window write", data_oe_o, 0);
    @(negedge clk);
    mreq_ni = 1; wr_ni = 1;

    // R2 aliasing across the window
    bus_write(2'd2, 8'h01, 10'h3AB);
    bus_read(2'd2, r, 10'h015);
    chk(r == 8'h01, "R2", "divider aliased readback", r, 8'h01);
    bus_write(2'd3, 8'h03, 10'h2C0);
    bus_read(2'd3, r, 10'h3FF);
    chk(r == 8'h03, "R2", "length aliased readback", r, 8'h03);

    // R4 / R8 select slave 0
    bus_write(2'd1, 8'h01);
    bus_read(2'd1, r);
    chk(r == 8'h01, "R4", "control readback", r, 8'h01);
    chk(ss_no == 2'b10, "R8", "slave 0 select", ss_no, 2'b10);

    xfer(8'hA5, 8'h3C, 2'b10, 1);
    chk(sclk_o == 0 && mosi_o == 1, "R5", "idle sclk low mosi high", {sclk_o, mosi_o}, 1);

    bus_write(2'd2, 8'h03);
    bus_write(2'd1, 8'h02);
    xfer(8'h5A, 8'hC3, 2'b01, 3);
    bus_write(2'd2, 8'h00);
    xfer(8'h81, 8'h7E, 2'b01, 0);

    // R10 writes while busy dropped
    bus_write(2'd2, 8'h02);
    exp_period = 6;
    begin
      item_t it;
      it.mosi = 8'h0F; it.ss = 2'b01;
      q.push_back(it);
    end
    sreg = 8'hF0;
    e0 = edges;
    bus_write(2'd0, 8'h0F);
    bus_read(2'd1, r);
    chk(r[7] == 1, "R10", "busy after start", r[7], 1);
    bus_write(2'd0, 8'h33);
    bus_write(2'd2, 8'h09);
    bus_write(2'd1, 8'h03);
    wait_idle();
    chk(edges - e0 == 8, "R10", "edges for one byte", edges - e0, 8);
    bus_read(2'd2, r);
    chk(r == 8'h02, "R10", "divider write dropped", r, 8'h02);
    bus_read(2'd1, r);
    chk(r == 8'h02, "R10", "control write dropped", r, 8'h02);
    bus_read(2'd0, r);
    chk(r == 8'hF0, "R7", "received byte", r, 8'hF0);

    // R9 clock burst of 3 bytes, data write during it dropped
    for (int i = 0; i < 3; i++) begin
      item_t it;
      it.mosi = 8'hFF; it.ss = 2'b11;
      q.push_back(it);
    end
    sreg = 8'h00;
    e0 = edges;
    bus_write(2'd1, 8'h06);
    bus_write(2'd0, 8'h55);
    wait_idle();
    chk(edges - e0 == 24, "R9", "burst pulse count", edges - e0, 24);
    chk(ss_no == 2'b01, "R8", "select restored after burst", ss_no, 2'b01);
    bus_read(2'd0, r);
    chk(r == 8'hF0, "R7", "rx kept over burst", r, 8'hF0);

    // R9 zero length
    bus_write(2'd3, 8'h00);
    e0 = edges;
    bus_write(2'd1, 8'h06);
    bus_read(2'd1, r);
    chk(r[7] == 0, "R9", "zero length not busy", r[7], 0);
    repeat (40) @(negedge clk);
    chk(edges == e0, "R9", "zero length pulses", edges - e0, 0);

    chk(q.size() == 0, "R5", "scoreboard drained", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule